// File: doc/BRIEF.md
# Split-Word 24-Bit Down Timer

This block is a down-counting timer whose count is twice as wide as the register bus that programs it. The count is 24 bits and the bus is 12 bits, so each value is written in two halves. The low half waits in a reload latch. Writing the high half of the count then loads all 24 bits in one cycle and starts the timer. Because the full value lands at once, the running counter never holds a mix of an old half and a new half.

Once started, the timer counts down by one on every clock. When it steps past zero it raises a sticky underflow flag and a one-cycle pulse. In one-shot mode it then stops at all ones. In free-running mode it reloads from the latch and keeps running. An optional compare variant (`HAS_CMP`) adds a 24-bit compare value, also written in two halves. That variant raises its own flag and pulse when the running count steps down from the compare value. Interrupt logic elsewhere on the chip can take the levels or the pulses.

Top module: `split_timer24`

## Requirements
- R1: After the asynchronous reset, the count, both latch halves, the mode and both compare halves are zero, and the timer is stopped. Both flags and both pulses are low.
- R2: A write to address 0 stores the write data in the low half of the reload latch only. The count does not change.
- R3: A write to address 1 loads count bits 11:0 from the low latch half as it was before that edge, and count bits 23:12 from the write data, in the same cycle. The write starts the timer and clears both flags.
- R4: Reads of address 0 and address 1 return bits 11:0 and bits 23:12 of the live count. While running, the count drops by exactly one per clock. Read data is combinational and is zero when chip select is low.
- R5: Addresses 2 and 3 read and write the low and high halves of the reload latch directly.
- R6: When a running count is zero at a clock edge with no load on that edge, the underflow flag sets and the underflow pulse is high for the following cycle. A set on the same edge as a clear wins.
- R7: With mode bit 0 clear (one-shot), an underflow moves the count to all ones and stops the timer. The timer then gives exactly one underflow per start.
- R8: With mode bit 0 set (free-running), an underflow reloads the count from the latch. Underflows repeat every latch+1 cycles.
- R9: A read of address 0 (chip select high, write enable low) clears the underflow flag.
- R10: In the compare variant, addresses 5 and 6 hold the low and high halves of the compare value. When a running count equals the compare value at an edge with no load, the compare flag sets and the compare pulse follows for one cycle. A read of address 5 or a write to address 1 clears the compare flag.
- R11: The mode register at address 4 is 1 bit wide in the compare variant and 2 bits wide otherwise. Only mode bit 0 affects counting. Without compare, addresses 5 and 6 read zero, ignore writes, and the compare outputs stay low. Address 7 always reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write enable; a read when low with cs_i high |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| unf_flag_o | output | 1 | Sticky underflow flag |
| unf_pulse_o | output | 1 | One-cycle underflow pulse |
| cmp_flag_o | output | 1 | Sticky compare flag |
| cmp_pulse_o | output | 1 | One-cycle compare pulse |

## Verification
The bench builds two copies on one bus, both with a 12-bit bus. The copy with `HAS_CMP=1` exercises compare hits, clears of the compare flag, and the 1-bit mode readback. The copy with `HAS_CMP=0` exposes the 2-bit mode, with an upper bit that has no effect, and the dead compare addresses. Latch values are kept small so that many underflows, reloads of zero and one-shot stops fit in the run. Both copies are compared every cycle against a cycle model kept in the bench.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_LAT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_LAT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd5;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd6;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import split_timer_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter bit HAS_CMP = 1'b1,
  localparam int CNT_W  = 2 * DATA_W,
  localparam int MODE_W = HAS_CMP ? 1 : 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  lat_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  cmp_o
);
  logic [DATA_W-1:0] lat_lo_q, lat_hi_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_lo_q <= '0;
      lat_hi_q <= '0;
      mode_q   <= '0;
    end else if (wr_i) begin
      if (addr_i == A_CNT_LO || addr_i == A_LAT_LO) lat_lo_q <= wdata_i;
      if (addr_i == A_LAT_HI) lat_hi_q <= wdata_i;
      if (addr_i == A_MODE)   mode_q   <= wdata_i[MODE_W-1:0];
    end
  end

  assign lat_o  = {lat_hi_q, lat_lo_q};
  assign mode_o = mode_q;

  generate
    if (HAS_CMP) begin : g_cmp
      logic [DATA_W-1:0] cmp_lo_q, cmp_hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cmp_lo_q <= '0;
          cmp_hi_q <= '0;
        end else if (wr_i) begin
          if (addr_i == A_CMP_LO) cmp_lo_q <= wdata_i;
          if (addr_i == A_CMP_HI) cmp_hi_q <= wdata_i;
        end
      end
      assign cmp_o = {cmp_hi_q, cmp_lo_q};
    end else begin : g_no_cmp
      assign cmp_o = '0;
    end
  endgenerate

  AST_LO_WRITE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CNT_LO) |=> lat_o[DATA_W-1:0] == $past(wdata_i)); // R2
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int DATA_W  = 12,
  parameter bit HAS_CMP = 1'b1,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              lo_wr_i,
  input  logic [DATA_W-1:0] ld_hi_i,
  input  logic [CNT_W-1:0]  lat_i,
  input  logic              free_i,
  input  logic [CNT_W-1:0]  cmp_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              unf_ev_o,
  output logic              cmp_ev_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign unf_ev_o = run_q && !ld_i && cnt_q == '0;
  assign cmp_ev_o = HAS_CMP && run_q && !ld_i && cnt_q == cmp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (ld_i) begin
      cnt_q <= {ld_hi_i, lat_i[DATA_W-1:0]};
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        // free-running reloads; one-shot parks at all ones
        cnt_q <= free_i ? lat_i : '1;
        run_q <= free_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  AST_LOAD_JOINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_o == {$past(ld_hi_i), $past(lat_i[DATA_W-1:0])}); // R3
  AST_LO_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr_i && !run_q) |=> $stable(cnt_o)); // R2
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_ev_o && !free_i) |=> (cnt_o == '1 && !run_q)); // R7
  AST_FREE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_ev_o && free_i) |=> cnt_o == $past(lat_i)); // R8
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= set_i;
      if (set_i)      flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  AST_PULSE_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> flag_o); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o); // R9
endmodule

// File: rtl/split_timer24.sv
module split_timer24
  import split_timer_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [2:0]        addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              unf_flag_o,
  output logic              unf_pulse_o,
  output logic              cmp_flag_o,
  output logic              cmp_pulse_o
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int MODE_W = HAS_CMP ? 1 : 2;

  logic              wr, rd, ld;
  logic [CNT_W-1:0]  lat, cmp, cnt;
  logic [MODE_W-1:0] mode;
  logic              unf_ev, cmp_ev;

  assign wr = cs_i && we_i;
  assign rd = cs_i && !we_i;
  assign ld = wr && addr_i == A_CNT_HI;

  tmr_regs #(.DATA_W(DATA_W), .HAS_CMP(HAS_CMP)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i, .wdata_i,
    .lat_o(lat), .mode_o(mode), .cmp_o(cmp)
  );

  tmr_cnt #(.DATA_W(DATA_W), .HAS_CMP(HAS_CMP)) u_cnt (
    .clk_i, .rst_ni, .ld_i(ld), .lo_wr_i(wr && addr_i == A_CNT_LO),
    .ld_hi_i(wdata_i), .lat_i(lat), .free_i(mode[0]), .cmp_i(cmp),
    .cnt_o(cnt), .unf_ev_o(unf_ev), .cmp_ev_o(cmp_ev)
  );

  tmr_flag u_unf (
    .clk_i, .rst_ni, .set_i(unf_ev), .clr_i(ld || (rd && addr_i == A_CNT_LO)),
    .flag_o(unf_flag_o), .pulse_o(unf_pulse_o)
  );

  generate
    if (HAS_CMP) begin : g_cmp_flag
      tmr_flag u_cmpf (
        .clk_i, .rst_ni, .set_i(cmp_ev), .clr_i(ld || (rd && addr_i == A_CMP_LO)),
        .flag_o(cmp_flag_o), .pulse_o(cmp_pulse_o)
      );
    end else begin : g_no_cmp_flag
      assign cmp_flag_o  = 1'b0;
      assign cmp_pulse_o = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (cs_i) begin
      case (addr_i)
        A_CNT_LO: rdata_o = cnt[DATA_W-1:0];
        A_CNT_HI: rdata_o = cnt[CNT_W-1:DATA_W];
        A_LAT_LO: rdata_o = lat[DATA_W-1:0];
        A_LAT_HI: rdata_o = lat[CNT_W-1:DATA_W];
        A_MODE:   rdata_o = DATA_W'(mode);
        A_CMP_LO: rdata_o = cmp[DATA_W-1:0];
        A_CMP_HI: rdata_o = cmp[CNT_W-1:DATA_W];
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_CMP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_CMP |-> (!cmp_flag_o && !cmp_pulse_o)); // R11
  AST_READ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> rdata_o == '0); // R4
  AST_CMP_PULSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_pulse_o |-> cmp_flag_o); // R10
endmodule

// File: tb/tb_split_timer24.sv
`timescale 1ns/1ps
module tb_split_timer24;
  localparam int DW = 12;
  localparam int CW = 2 * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, we = 0;
  logic [2:0] addr = 0;
  logic [DW-1:0] wd = 0;
  logic [DW-1:0] rd1, rd2;
  logic uf1, up1, cf1, cp1, uf2, up2, cf2, cp2;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  split_timer24 #(.DATA_W(DW), .HAS_CMP(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .addr_i(addr), .we_i(we), .wdata_i(wd),
    .rdata_o(rd1), .unf_flag_o(uf1), .unf_pulse_o(up1), .cmp_flag_o(cf1), .cmp_pulse_o(cp1));
  split_timer24 #(.DATA_W(DW), .HAS_CMP(1'b0)) dut_nc (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .addr_i(addr), .we_i(we), .wdata_i(wd),
    .rdata_o(rd2), .unf_flag_o(uf2), .unf_pulse_o(up2), .cmp_flag_o(cf2), .cmp_pulse_o(cp2));

  // cycle model built from the requirements
  logic [CW-1:0] m_cnt, m_lat, m_cmp;
  logic [1:0]    m_mode;
  logic m_run, m_uf, m_up, m_cf, m_cp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_lat <= 0; m_cmp <= 0; m_mode <= 0; m_run <= 0;
      m_uf <= 0; m_up <= 0; m_cf <= 0; m_cp <= 0;
    end else begin
      logic ld, uev, cev;
      ld  = cs && we && addr == 3'd1;
      uev = m_run && !ld && m_cnt == 0;
      cev = m_run && !ld && m_cnt == m_cmp;
      if (ld) begin m_cnt <= {wd, m_lat[DW-1:0]}; m_run <= 1; end
      else if (m_run) begin
        if (m_cnt == 0) begin m_cnt <= m_mode[0] ? m_lat : '1; m_run <= m_mode[0]; end
        else m_cnt <= m_cnt - 1;
      end
      if (cs && we) begin
        if (addr == 0 || addr == 2) m_lat[DW-1:0] <= wd;
        if (addr == 3) m_lat[CW-1:DW] <= wd;
        if (addr == 4) m_mode <= wd[1:0];
        if (addr == 5) m_cmp[DW-1:0] <= wd;
        if (addr == 6) m_cmp[CW-1:DW] <= wd;
      end
      m_up <= uev; m_cp <= cev;
      if (uev) m_uf <= 1; else if (ld || (cs && !we && addr == 0)) m_uf <= 0;
      if (cev) m_cf <= 1; else if (ld || (cs && !we && addr == 5)) m_cf <= 0;
    end
  end

  function automatic logic [DW-1:0] exp_rd(input logic [2:0] a, input bit has_cmp);
    case (a)
      3'd0: return m_cnt[DW-1:0];
      3'd1: return m_cnt[CW-1:DW];
      3'd2: return m_lat[DW-1:0];
      3'd3: return m_lat[CW-1:DW];
      3'd4: return has_cmp ? DW'(m_mode[0]) : DW'(m_mode);
      3'd5: return has_cmp ? m_cmp[DW-1:0] : '0;
      3'd6: return has_cmp ? m_cmp[CW-1:DW] : '0;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle flag and pulse comparison
  bit live = 0;
  always @(negedge clk) if (live && rst_n) begin
    check("R6 unf pulse", 32'(up1), 32'(m_up));
    check("R9 unf flag",  32'(uf1), 32'(m_uf));
    check("R10 cmp pulse", 32'(cp1), 32'(m_cp));
    check("R10 cmp flag",  32'(cf1), 32'(m_cf));
    check("R7 R8 unf pulse nc", 32'(up2), 32'(m_up));
    check("R11 cmp quiet nc", 32'({cf2, cp2}), 32'(0));
  end

  // one bus cycle, entered and left at a falling edge
  task automatic bus(input bit c, input bit w, input logic [2:0] a, input logic [DW-1:0] d);
    cs = c; we = w; addr = a; wd = d;
    #1;
    if (c && !w) begin
      check($sformatf("R4 R5 read a%0d", a), 32'(rd1), 32'(exp_rd(a, 1)));
      check($sformatf("R11 read nc a%0d", a), 32'(rd2), 32'(exp_rd(a, 0)));
    end
    if (!c) check("R4 idle rdata", 32'(rd1), 32'(0));
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bus(0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flags", 32'({uf1, up1, cf1, cp1, uf2, up2}), 32'(0));
    rst_n = 1;
    @(negedge clk);
    live = 1;
    for (int a = 0; a < 8; a++) bus(1, 0, 3'(a), 0);   // R1 all registers zero
    // R2: low write leaves count alone
    bus(1, 1, 0, 12'h00a);
    bus(1, 0, 0, 0);
    check("R2 count unchanged", 32'(rd1), 32'(0));
    bus(1, 0, 2, 0);
    // R3 + R7: one-shot start, stop at all ones
    bus(1, 1, 1, 12'h000);
    idle(14);
    bus(1, 0, 0, 0);
    check("R7 parked low", 32'(m_cnt), 32'(24'hffffff));
    bus(1, 0, 1, 0);
    idle(5);
    // R8 free-running with latch 3, R11 mode bit1 ignored on nc copy
    bus(1, 1, 4, 12'h003);
    bus(1, 1, 2, 12'h003);
    bus(1, 1, 3, 12'h000);
    bus(1, 1, 1, 12'h000);
    idle(12);
    bus(1, 0, 4, 0);
    bus(1, 0, 0, 0);                    // R9 clear by read
    // R8 zero reload: pulse every cycle
    bus(1, 1, 2, 12'h000);
    bus(1, 1, 0, 12'h000);
    bus(1, 1, 1, 12'h000);
    idle(6);
    // R10 compare
    bus(1, 1, 5, 12'h004);
    bus(1, 1, 6, 12'h000);
    bus(1, 1, 2, 12'h009);
    bus(1, 1, 1, 12'h000);
    idle(8);
    bus(1, 0, 5, 0);
    bus(1, 0, 6, 0);
    idle(4);
    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0: bus(1, 1, 4, 12'($urandom_range(0, 3)));
        1: bus(1, 1, 3'($urandom_range(0, 2) == 0 ? 0 : 2), 12'($urandom_range(0, 12)));
        2: bus(1, 1, 3, 12'($urandom_range(0, 9) == 0 ? 1 : 0));
        3: bus(1, 1, 1, 12'($urandom_range(0, 9) == 0 ? 1 : 0));
        4: bus(1, 1, 3'($urandom_range(5, 6)), 12'($urandom_range(0, 12)));
        5: bus(1, 1, 6, 12'h000);
        6: bus(1, 0, 3'($urandom_range(0, 7)), 0);
        default: idle($urandom_range(1, 6));
      endcase
    end
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule